// File: doc/BRIEF.md
# Direct-Mapped Word Cache Controller

This block sits between a processor that issues 16-bit word addresses and a 64K-word main memory of 12-bit words. It keeps 256 single-word lines. Each line holds one 12-bit data word, an 8-bit tag and a valid flag. For each access the address is split into two fields. The low byte picks the line and the high byte is compared with the stored tag. Each memory word can live in exactly one line, so there is never a choice of which line to replace. A new address whose index matches a resident line with a different tag simply overwrites that line when it is fetched.

Reads that hit return the stored word one cycle after the request. A read miss fetches the word over a request/acknowledge handshake, installs it in the line and then returns it. Writes always go to main memory. The cached copy is updated only when the written address is already resident, and a write miss does not allocate a line. Each completed access reports whether it hit.

Top module: `dmCache`

## Requirements
- R1: After reset no line is valid, so the first read of any address is a miss; while reset is released and idle, `cpuReady` and `memReq` are 0.
- R2: The line index is `cpuAddr[7:0]` and the tag is `cpuAddr[15:8]`. Addresses differing only in the high byte share a line, and addresses differing in the low byte use different lines.
- R3: A read that hits raises `cpuReady` for exactly one cycle, in the cycle right after the request cycle, with the line's word on `cpuRdata`. No memory request is made.
- R4: On a read miss `memReq` is raised with `memWe`=0 and `memAddr` equal to the CPU address. Both are held steady until `memAck` is seen.
- R5: On a read miss, `cpuReady` pulses in the cycle after the `memAck` cycle, carrying the `memRdata` value sampled with the acknowledge. A later read of the same address hits with that value.
- R6: A read miss to an index whose resident line has a different tag replaces that line. A following read of the old address misses.
- R7: Every write raises `memReq` with `memWe`=1, `memAddr` equal to the CPU address and `memWdata` equal to the CPU write data, whether it hits or misses.
- R8: A write that hits updates the cached word, and a following read of that address hits with the new data.
- R9: A write that misses leaves the cache unchanged. A following read of that address misses, and the line already resident at that index still hits.
- R10: `cpuHit` is valid while `cpuReady` is 1. It is 1 when the addressed line was valid with a matching tag at lookup, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Access request strobe, sampled only when the controller is idle |
| cpuWe | input | 1 | 1 for a write access, 0 for a read |
| cpuAddr | input | 16 | Word address of the access |
| cpuWdata | input | 12 | Write data |
| cpuRdata | output | 12 | Read data, valid while cpuReady is 1 |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | Hit status of the completed access |
| memReq | output | 1 | Main-memory request, held until memAck |
| memWe | output | 1 | 1 for a memory write, 0 for a read |
| memAddr | output | 16 | Main-memory word address |
| memWdata | output | 12 | Main-memory write data |
| memRdata | input | 12 | Main-memory read data, valid with memAck |
| memAck | input | 1 | Main-memory acknowledge, one cycle |

## Verification
The bench looks for a design that ignores the tag and so returns stale data on an index collision. It also checks that an evicted line is not left valid, so that the old address is served wrongly from the cache. A write miss that wrongly allocates is caught because the next read would hit. The bench also targets a write hit that skips main memory, and a write hit that leaves the old word cached. Boundary indices 0x00 and 0xFF are used, and bus ordering is checked: `memReq` must hold until the acknowledge, `cpuReady` must last exactly one cycle, and it must come one cycle after the request on a hit.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEMRD,
    ST_MEMWR,
    ST_RESP
  } ctlState_t;

  typedef struct packed {
    logic latchReq;   // capture CPU request into the datapath
    logic fillLine;   // install tag, fetched word and valid flag
    logic writeLine;  // overwrite data word of a resident line
    logic captureRd;  // hold fetched word for the response cycle
    logic selResp;    // drive the held word instead of the array word
  } dpStrobes_t;
endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              reqWe,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] respData;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES];
  logic [LINES-1:0]  validBits;

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [DATA_W-1:0] lookupData;

  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
      respData <= '0;
    end else begin
      if (strb.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        reqWe    <= cpuWe;
      end
      if (strb.captureRd) respData <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) validBits <= '0;
    else if (strb.fillLine) validBits[reqIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      tagMem[reqIdx]  <= reqTag;
      dataMem[reqIdx] <= memRdata;
    end else if (strb.writeLine) begin
      dataMem[reqIdx] <= reqWdata;
    end
  end

  assign lookupData = dataMem[reqIdx];
  assign lookupHit  = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign memAddr    = reqAddr;
  assign memWdata   = reqWdata;
  assign cpuRdata   = strb.selResp ? respData : lookupData;

  AST_FILL_MAKES_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> lookupHit) else $error("fill did not install line"); // R5
  AST_WRITE_UPDATES: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeLine |=> (lookupData == $past(reqWdata))) else $error("write hit not stored"); // R8
endmodule

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       reqWe,
  input  logic       lookupHit,
  input  logic       memAck,
  output dpStrobes_t strb,
  output logic       cpuReady,
  output logic       cpuHit,
  output logic       memReq,
  output logic       memWe
);
  ctlState_t state, stateNxt;
  logic hitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hitReg <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_LOOKUP) hitReg <= lookupHit;
    end
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        strb.latchReq = cpuReq;
        if (cpuReq) stateNxt = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (reqWe)          stateNxt = ST_MEMWR;
        else if (lookupHit) stateNxt = ST_IDLE;
        else                stateNxt = ST_MEMRD;
      end
      ST_MEMRD: begin
        if (memAck) begin
          strb.fillLine  = 1'b1;
          strb.captureRd = 1'b1;
          stateNxt       = ST_RESP;
        end
      end
      ST_MEMWR: begin
        if (memAck) begin
          strb.writeLine = hitReg;
          stateNxt       = ST_RESP;
        end
      end
      ST_RESP: begin
        strb.selResp = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign memReq   = (state == ST_MEMRD) || (state == ST_MEMWR);
  assign memWe    = (state == ST_MEMWR);
  assign cpuReady = (state == ST_RESP) || ((state == ST_LOOKUP) && !reqWe && lookupHit);
  assign cpuHit   = (state == ST_LOOKUP) ? lookupHit : hitReg;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe))) else $error("request dropped"); // R4
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady) else $error("ready longer than a cycle"); // R3
  AST_NO_READY_WHILE_MEM: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady) else $error("ready during memory access"); // R5
  AST_WRITE_GOES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_LOOKUP) && reqWe) |=> (memReq && memWe)) else $error("write skipped memory"); // R7
endmodule

// File: rtl/dmCache.sv
module dmCache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              cpuHit,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  dpStrobes_t strb;
  logic reqWe;
  logic lookupHit;

  dmc_control u_control (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .reqWe(reqWe),
    .lookupHit(lookupHit), .memAck(memAck), .strb(strb),
    .cpuReady(cpuReady), .cpuHit(cpuHit), .memReq(memReq), .memWe(memWe)
  );

  dmc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .reqWe(reqWe),
    .lookupHit(lookupHit), .memAddr(memAddr), .memWdata(memWdata),
    .cpuRdata(cpuRdata)
  );
endmodule

// File: tb/dmCache_bench.sv
module dmCache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [11:0] cpuWdata = '0;
  logic [11:0] cpuRdata;
  logic        cpuReady, cpuHit, memReq, memWe;
  logic [15:0] memAddr;
  logic [11:0] memWdata;
  logic [11:0] memRdata = '0;
  logic        memAck = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [11:0] written [int];

  always #10 clk = ~clk;

  dmCache u_dmCache (.*);

  function automatic logic [11:0] model(input logic [15:0] a);
    if (written.exists(int'(a))) return written[int'(a)];
    return a[11:0] ^ {a[15:12], a[15:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: acknowledges on the third cycle of a request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        cnt = 0;
      end else if (memReq) begin
        cnt++;
        if (cnt == 3) begin
          if (memWe) written[int'(memAddr)] = memWdata;
          memRdata = model(memAddr);
          memAck = 1'b1;
        end
      end
    end
  end

  // one access; returns data, hit flag, latency and what appeared on the memory side
  task automatic access(input logic we, input logic [15:0] a, input logic [11:0] wd,
                        output logic [11:0] rd, output logic hit, output int lat,
                        output logic sawReq, output logic sawWe,
                        output logic [15:0] sawAddr, output logic [11:0] sawWd);
    sawReq = 0; sawWe = 0; sawAddr = '0; sawWd = '0;
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    @(negedge clk);
    cpuReq = 0;
    lat = 1;
    while (!cpuReady && lat < 100) begin
      if (memReq) begin
        sawReq = 1; sawWe = memWe; sawAddr = memAddr; sawWd = memWdata;
      end
      @(negedge clk);
      lat++;
    end
    rd = cpuRdata; hit = cpuHit;
    if (lat >= 100) check("watchdog", 1, 0);
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 ready idle", cpuReady, 0);
    check("R1 memReq idle", memReq, 0);
  endtask

  task automatic tReadMissThenHit(input logic [15:0] a);
    logic [11:0] rd; logic hit; int lat; logic sr, sw; logic [15:0] sa; logic [11:0] sd;
    access(0, a, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R1 first read misses", hit, 0);
    check("R4 read miss requests", sr, 1);
    check("R4 read miss memWe", sw, 0);
    check("R4 read miss address", sa, a);
    check("R5 miss data", rd, model(a));
    check("R5 miss latency", lat, 5);
    access(0, a, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R10 hit flag", hit, 1);
    check("R3 hit data", rd, model(a));
    check("R3 hit latency", lat, 1);
    check("R3 hit no memory", sr, 0);
    @(negedge clk);
    check("R3 ready one cycle", cpuReady, 0);
  endtask

  task automatic tConflict();
    logic [11:0] rd; logic hit; int lat; logic sr, sw; logic [15:0] sa; logic [11:0] sd;
    access(0, 16'h1234, 0, rd, hit, lat, sr, sw, sa, sd);
    access(0, 16'h1235, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R2 neighbour index misses", hit, 0);
    access(0, 16'h1234, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R2 own line still hits", hit, 1);
    access(0, 16'h5634, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R6 same index other tag misses", hit, 0);
    check("R6 new data", rd, model(16'h5634));
    access(0, 16'h1234, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R6 evicted address misses", hit, 0);
    check("R6 evicted data refetched", rd, model(16'h1234));
  endtask

  task automatic tWriteHit();
    logic [11:0] rd; logic hit; int lat; logic sr, sw; logic [15:0] sa; logic [11:0] sd;
    access(0, 16'hA0FF, 0, rd, hit, lat, sr, sw, sa, sd);
    access(1, 16'hA0FF, 12'h5A5, rd, hit, lat, sr, sw, sa, sd);
    check("R7 write hit reaches memory", sr, 1);
    check("R7 write memWe", sw, 1);
    check("R7 write address", sa, 16'hA0FF);
    check("R7 write data", sd, 12'h5A5);
    check("R10 write hit flag", hit, 1);
    access(0, 16'hA0FF, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R8 read after write hits", hit, 1);
    check("R8 updated data", rd, 12'h5A5);
  endtask

  task automatic tWriteMiss();
    logic [11:0] rd; logic hit; int lat; logic sr, sw; logic [15:0] sa; logic [11:0] sd;
    access(0, 16'h3300, 0, rd, hit, lat, sr, sw, sa, sd);
    access(1, 16'h7700, 12'h3C3, rd, hit, lat, sr, sw, sa, sd);
    check("R7 write miss reaches memory", sr, 1);
    check("R7 write miss data", sd, 12'h3C3);
    check("R10 write miss flag", hit, 0);
    access(0, 16'h3300, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R9 resident line kept", hit, 1);
    check("R9 resident data kept", rd, model(16'h3300));
    access(0, 16'h7700, 0, rd, hit, lat, sr, sw, sa, sd);
    check("R9 no allocate on write miss", hit, 0);
    check("R9 memory holds written word", rd, 12'h3C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tReadMissThenHit(16'h0000);
    tReadMissThenHit(16'hFFFF);
    tConflict();
    tWriteHit();
    tWriteMiss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule